// File: doc/BRIEF.md
# Load/Store Decode and Execute Unit

This unit accepts one memory instruction at a time. The instruction is either a 16-bit short form in the low half of the instruction word or a 32-bit long form. The unit decodes it and forms the effective address. It then carries out one byte, halfword or word transfer over a valid/ready memory port. A load's result goes back into an internal file of 32 general registers.

Short forms address memory relative to a pointer value that arrives on an input port. Their displacements are unsigned and are scaled by the access size. Long forms add a sign-extended 16-bit displacement to a base register. The halfword and word variants of a long form share one opcode and are split by the lowest displacement bit.

While an access is in flight the unit reports busy and takes no new instruction. An unrecognised word is rejected with a one-cycle flag and leaves memory and registers untouched.

Top module: `ldst_unit`

## Requirements
- R1: Short forms keep the data register in bits [15:11] and a 4-bit opcode in bits [10:7]. The opcodes are 0110 byte load, 0111 byte store, 1000 halfword load, 1001 halfword store, and 1010 word access, where bit 0 selects load (0) or store (1). The address is the pointer input plus a zero-extended displacement. That displacement is bits [6:0] for byte forms, bits [6:0] times 2 for halfword forms and bits [6:1] times 4 for word forms.
- R2: Long forms keep the data register in bits [15:11], a 6-bit opcode in bits [10:5] and the base register in bits [4:0]. The opcodes are 111000 byte load, 111001 halfword/word load, 111010 byte store and 111011 halfword/word store; for the halfword/word opcodes, bit 16 is 0 for halfword and 1 for word. The address is the base register plus bits [31:16] sign-extended, with bit 16 taken as zero for the halfword/word opcodes.
- R3: Byte enables are little-endian. A byte access sets bit addr[1:0] only. A halfword access sets 0011 when addr[1] is 0 and 1100 when it is 1. A word access sets 1111.
- R4: A store drives memWrite high and puts the source register's low byte on all four lanes, or its low halfword on both halves, or the full word.
- R5: A byte or halfword load takes the lane named by the address and sign-extends it to 32 bits. A word load writes the read data unchanged.
- R6: memValid stays high with address, enables, write data and direction stable until memReady is seen. busy is high from the cycle after acceptance until the operation ends. Instruction words presented while busy are not taken.
- R7: A load writes its register in the cycle after the read data is accepted, and busy falls one cycle later. A store ends, with busy low, in the cycle after memReady.
- R8: A word with any other opcode raises illegal for exactly one cycle after acceptance. It starts no memory access, writes no register and leaves busy low.
- R9: Register 0 always reads as zero, and loads into it are discarded.
- R10: After reset busy, memValid and illegal are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction word offered; taken when busy is low |
| instrWord | input | 32 | Instruction; short forms use bits [15:0] |
| epReg | input | 32 | Pointer value used as the base of short forms |
| busy | output | 1 | An accepted instruction is still in progress |
| illegal | output | 1 | One-cycle pulse after an unrecognised word is taken |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts the request, and its read data, this cycle |
| memWrite | output | 1 | 1 for store, 0 for load |
| memAddr | output | 32 | Effective byte address |
| memByteEn | output | 4 | Byte-lane enables, lane 0 holds the lowest address |
| memWdata | output | 32 | Store data, replicated across the active lanes |
| memRdata | input | 32 | Load data, valid with memReady |

## Verification
A table of instructions covers every short and long opcode. Displacement fields are chosen to tell the scaling rules apart: all-ones short fields, the halfword/word select bit set and cleared, and a negative long displacement that wraps the address. Loaded values are chosen to separate sign extension from zero extension and to show which byte lane was picked; each loaded register is then read back by a word store. Directed cases cover register 0, several unrecognised opcodes, and words offered while a stalled access waits. They also check the reset contents of the register file.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int XLEN      = 32;
  localparam int NREGS     = 32;
  localparam int REG_IDX_W = $clog2(NREGS);
  localparam int LANES     = XLEN / 8;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} sizeT;

  typedef struct packed {
    logic                 legal;
    logic                 isStore;
    logic                 useEp;
    sizeT                 size;
    logic [REG_IDX_W-1:0] dataReg;
    logic [REG_IDX_W-1:0] baseReg;
    logic [XLEN-1:0]      offset;
  } decT;

  typedef struct packed {
    logic latchInstr;
    logic captureRead;
    logic writeBack;
  } strobeT;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_WB} stateT;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [31:0] word,
  output decT         dec
);
  always_comb begin
    dec         = '0;
    dec.dataReg = word[15:11];
    dec.baseReg = word[4:0];
    case (word[10:7])
      4'b0110, 4'b0111: begin
        dec.legal   = 1'b1;
        dec.useEp   = 1'b1;
        dec.isStore = word[7];
        dec.size    = SZ_BYTE;
        dec.offset  = {25'd0, word[6:0]};
      end
      4'b1000, 4'b1001: begin
        dec.legal   = 1'b1;
        dec.useEp   = 1'b1;
        dec.isStore = word[7];
        dec.size    = SZ_HALF;
        dec.offset  = {24'd0, word[6:0], 1'b0};
      end
      4'b1010: begin
        dec.legal   = 1'b1;
        dec.useEp   = 1'b1;
        dec.isStore = word[0];
        dec.size    = SZ_WORD;
        dec.offset  = {24'd0, word[6:1], 2'b00};
      end
      4'b1110: begin
        dec.legal   = 1'b1;
        dec.isStore = word[6];
        if (!word[5]) begin
          dec.size   = SZ_BYTE;
          dec.offset = {{16{word[31]}}, word[31:16]};
        end else begin
          dec.size   = word[16] ? SZ_WORD : SZ_HALF;
          dec.offset = {{16{word[31]}}, word[31:17], 1'b0};
        end
      end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   instrValid,
  input  logic   decLegal,
  input  logic   decStore,
  input  logic   memReady,
  output logic   busy,
  output logic   memValid,
  output logic   illegal,
  output strobeT strobe
);
  stateT state;
  logic  storeOp;
  logic  accept;

  assign accept   = instrValid && (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign memValid = (state == ST_ACCESS);

  always_comb begin
    strobe             = '0;
    strobe.latchInstr  = accept && decLegal;
    strobe.captureRead = (state == ST_ACCESS) && memReady && !storeOp;
    strobe.writeBack   = (state == ST_WB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      storeOp <= 1'b0;
      illegal <= 1'b0;
    end else begin
      illegal <= accept && !decLegal;
      case (state)
        ST_IDLE: if (accept && decLegal) begin
          state   <= ST_ACCESS;
          storeOp <= decStore;
        end
        ST_ACCESS: if (memReady) state <= storeOp ? ST_IDLE : ST_WB;
        ST_WB:     state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  decT              dec,
  input  logic [XLEN-1:0]  epReg,
  input  logic [XLEN-1:0]  memRdata,
  output logic [XLEN-1:0]  memAddr,
  output logic [LANES-1:0] memByteEn,
  output logic [XLEN-1:0]  memWdata,
  output logic             memWrite
);
  decT             cur;
  logic [XLEN-1:0] regFile [NREGS];
  logic [XLEN-1:0] baseVal;
  logic [XLEN-1:0] srcVal;
  logic [XLEN-1:0] effAddr;
  logic [XLEN-1:0] loadVal;
  logic [XLEN-1:0] loadBuf;
  logic [7:0]      laneByte;
  logic [15:0]     laneHalf;

  assign baseVal  = (cur.baseReg == '0) ? '0 : regFile[cur.baseReg];
  assign srcVal   = regFile[cur.dataReg];
  assign effAddr  = (cur.useEp ? epReg : baseVal) + cur.offset;
  assign memAddr  = effAddr;
  assign memWrite = cur.isStore && cur.legal;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign memByteEn[l] = (cur.size == SZ_WORD) ||
                          ((cur.size == SZ_HALF) && (effAddr[1] == 1'((l / 2)))) ||
                          ((cur.size == SZ_BYTE) && (effAddr[1:0] == 2'(l)));
  end

  always_comb begin
    case (cur.size)
      SZ_BYTE: memWdata = {LANES{srcVal[7:0]}};
      SZ_HALF: memWdata = {(LANES / 2){srcVal[15:0]}};
      default: memWdata = srcVal;
    endcase
  end

  always_comb begin
    laneByte = memRdata[{effAddr[1:0], 3'b000} +: 8];
    laneHalf = effAddr[1] ? memRdata[31:16] : memRdata[15:0];
    case (cur.size)
      SZ_BYTE: loadVal = {{(XLEN - 8){laneByte[7]}}, laneByte};
      SZ_HALF: loadVal = {{(XLEN - 16){laneHalf[15]}}, laneHalf};
      default: loadVal = memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur     <= '0;
      loadBuf <= '0;
    end else begin
      if (strobe.latchInstr)  cur     <= dec;
      if (strobe.captureRead) loadBuf <= loadVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regFile[i] <= '0;
    end else if (strobe.writeBack && (cur.dataReg != '0)) begin
      regFile[cur.dataReg] <= loadBuf;
    end
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  input  logic [31:0] epReg,
  output logic        busy,
  output logic        illegal,
  output logic        memValid,
  input  logic        memReady,
  output logic        memWrite,
  output logic [31:0] memAddr,
  output logic [3:0]  memByteEn,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata
);
  decT    dec;
  strobeT strobe;

  ldst_decode decode_i (.word(instrWord), .dec(dec));

  ldst_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .decLegal(dec.legal), .decStore(dec.isStore), .memReady(memReady),
    .busy(busy), .memValid(memValid), .illegal(illegal), .strobe(strobe)
  );

  ldst_datapath datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dec(dec), .epReg(epReg),
    .memRdata(memRdata), .memAddr(memAddr), .memByteEn(memByteEn),
    .memWdata(memWdata), .memWrite(memWrite)
  );
endmodule

// File: rtl/ldst_unit_checker.sv
module ldst_unit_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        illegal,
  input logic        memValid,
  input logic        memReady,
  input logic        memWrite,
  input logic [31:0] memAddr,
  input logic [3:0]  memByteEn,
  input logic [31:0] memWdata
);
  a_r6_request_held: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memByteEn)
                              && $stable(memWdata) && $stable(memWrite));

  a_r6_busy_during_access: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> busy);

  a_r3_lane_count: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> ($countones(memByteEn) == 1 || $countones(memByteEn) == 2
                  || $countones(memByteEn) == 4));

  a_r3_half_lanes: assert property (@(posedge clk) disable iff (!rstN)
    memValid && $countones(memByteEn) == 2 |-> (memByteEn == 4'b0011 || memByteEn == 4'b1100));

  a_r7_load_writeback_cycle: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && !memWrite |=> busy && !memValid);

  a_r7_store_done: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && memWrite |=> !busy);

  a_r8_no_access: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !memValid && !busy);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> !illegal);
endmodule

bind ldst_unit ldst_unit_checker chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .illegal(illegal), .memValid(memValid),
  .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr),
  .memByteEn(memByteEn), .memWdata(memWdata)
);

// File: tb/ldst_unit_tb_top.sv
`timescale 1ns/1ps
module ldst_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] epReg = 32'h0000_1000;
  logic        busy, illegal, memValid, memWrite;
  logic        memReady = 1'b0;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic [3:0]  memByteEn;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ldst_unit dut_i (.*);

  typedef struct packed {
    logic        isLong;
    logic [5:0]  op;
    logic [4:0]  dReg;
    logic [4:0]  bReg;
    logic [15:0] dField;
    logic [31:0] rdata;
    logic        expWrite;
    logic [31:0] expAddr;
    logic [3:0]  expBe;
    logic [31:0] expWdata;
  } vecT;

  localparam int NV = 22;
  localparam vecT VECS [NV] = '{
    '{1'b1, 6'h39, 5'd5,  5'd0, 16'h0101, 32'h8899AABB, 1'b0, 32'h00000100, 4'hF, 32'h0},        // R2 word load
    '{1'b0, 6'h0A, 5'd5,  5'd0, 16'h0005, 32'h0,        1'b1, 32'h00001008, 4'hF, 32'h8899AABB}, // R1 R5 word
    '{1'b0, 6'h06, 5'd6,  5'd0, 16'h007F, 32'h80000000, 1'b0, 32'h0000107F, 4'h8, 32'h0},        // R1 byte lane 3
    '{1'b0, 6'h0A, 5'd6,  5'd0, 16'h0001, 32'h0,        1'b1, 32'h00001000, 4'hF, 32'hFFFFFF80}, // R5 sign
    '{1'b0, 6'h08, 5'd7,  5'd0, 16'h0003, 32'h80011234, 1'b0, 32'h00001006, 4'hC, 32'h0},        // R1 half upper
    '{1'b0, 6'h09, 5'd7,  5'd0, 16'h0001, 32'h0,        1'b1, 32'h00001002, 4'hC, 32'h80018001}, // R4 half
    '{1'b0, 6'h07, 5'd7,  5'd0, 16'h0005, 32'h0,        1'b1, 32'h00001005, 4'h2, 32'h01010101}, // R4 byte
    '{1'b0, 6'h08, 5'd11, 5'd0, 16'h0002, 32'h0000F00F, 1'b0, 32'h00001004, 4'h3, 32'h0},        // R3 half lower
    '{1'b0, 6'h0A, 5'd11, 5'd0, 16'h0003, 32'h0,        1'b1, 32'h00001004, 4'hF, 32'hFFFFF00F}, // R5
    '{1'b0, 6'h06, 5'd12, 5'd0, 16'h0001, 32'h00009A00, 1'b0, 32'h00001001, 4'h2, 32'h0},        // R3 byte lane 1
    '{1'b0, 6'h0A, 5'd12, 5'd0, 16'h0005, 32'h0,        1'b1, 32'h00001008, 4'hF, 32'hFFFFFF9A}, // R5
    '{1'b1, 6'h38, 5'd8,  5'd6, 16'h0100, 32'h1111117F, 1'b0, 32'h00000080, 4'h1, 32'h0},        // R2 base reg
    '{1'b1, 6'h3A, 5'd8,  5'd0, 16'hFFFE, 32'h0,        1'b1, 32'hFFFFFFFE, 4'h4, 32'h7F7F7F7F}, // R2 negative
    '{1'b1, 6'h39, 5'd9,  5'd0, 16'h8002, 32'h12345678, 1'b0, 32'hFFFF8002, 4'hC, 32'h0},        // R2 half
    '{1'b1, 6'h3B, 5'd9,  5'd0, 16'h0011, 32'h0,        1'b1, 32'h00000010, 4'hF, 32'h00001234}, // R2 word store
    '{1'b1, 6'h3B, 5'd9,  5'd0, 16'h0020, 32'h0,        1'b1, 32'h00000020, 4'h3, 32'h12341234}, // R2 half store
    '{1'b1, 6'h39, 5'd13, 5'd8, 16'hFFF1, 32'h01020304, 1'b0, 32'h0000006F, 4'hF, 32'h0},        // R2 wrap
    '{1'b0, 6'h0A, 5'd13, 5'd0, 16'h0001, 32'h0,        1'b1, 32'h00001000, 4'hF, 32'h01020304},
    '{1'b1, 6'h39, 5'd0,  5'd0, 16'h0005, 32'hDEADBEEF, 1'b0, 32'h00000004, 4'hF, 32'h0},        // R9 load r0
    '{1'b0, 6'h0A, 5'd0,  5'd0, 16'h0001, 32'h0,        1'b1, 32'h00001000, 4'hF, 32'h00000000}, // R9
    '{1'b0, 6'h0A, 5'd10, 5'd0, 16'h007E, 32'hCAFEF00D, 1'b0, 32'h000010FC, 4'hF, 32'h0},        // R1 max disp
    '{1'b0, 6'h0A, 5'd10, 5'd0, 16'h007F, 32'h0,        1'b1, 32'h000010FC, 4'hF, 32'hCAFEF00D}
  };

  function automatic logic [31:0] encode(vecT v);
    if (v.isLong) return {v.dField, v.dReg, v.op, v.bReg};
    return {16'h0, v.dReg, v.op[3:0], v.dField[6:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = w;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic runVec(input vecT v, input int stall);
    issue(encode(v));
    chk("R6 memValid", 32'(memValid), 32'd1);
    chk("R4 memWrite", 32'(memWrite), 32'(v.expWrite));
    chk(v.isLong ? "R2 addr" : "R1 addr", memAddr, v.expAddr);
    chk("R3 byteEn", 32'(memByteEn), 32'(v.expBe));
    if (v.expWrite) chk("R4/R5/R9 wdata", memWdata, v.expWdata);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R6 held", {memValid, memAddr[30:0]}, {1'b1, v.expAddr[30:0]});
    end
    memReady = 1'b1;
    memRdata = v.rdata;
    @(negedge clk);
    memReady = 1'b0;
    memRdata = '0;
    if (!v.expWrite) begin
      chk("R7 writeback cycle", {30'd0, busy, memValid}, 32'b10);
      @(negedge clk);
    end
    chk("R7 done", 32'(busy), 32'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    vecT v;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy", 32'(busy), 32'd0);
    chk("R10 memValid", 32'(memValid), 32'd0);
    chk("R10 illegal", 32'(illegal), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R10: register 3 reads zero after reset
    v = '{1'b0, 6'h0A, 5'd3, 5'd0, 16'h0001, 32'h0, 1'b1, 32'h00001000, 4'hF, 32'h0};
    runVec(v, 0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i % 3);

    // R8: unrecognised opcodes
    for (int k = 0; k < 3; k++) begin
      logic [31:0] w;
      w = (k == 0) ? 32'h0000_5000 : (k == 1) ? 32'h0000_2F80 : 32'h0000_12A5;
      issue(w);
      chk("R8 illegal pulse", {29'd0, illegal, memValid, busy}, 32'b100);
      @(negedge clk);
      chk("R8 illegal clears", {29'd0, illegal, memValid, busy}, 32'b000);
    end

    // R6: words offered while busy are not taken
    epReg = 32'h0000_2000;
    issue({16'h0, 5'd14, 4'b1010, 7'h00});
    chk("R6 load started", {memValid, memWrite, memAddr[29:0]}, {2'b10, 30'h0000_2000});
    instrValid = 1'b1;
    instrWord  = {16'h0, 5'd10, 4'b1010, 7'h03};
    repeat (3) begin
      @(negedge clk);
      chk("R6 busy ignores word", {memValid, memWrite, memAddr[29:0]}, {2'b10, 30'h0000_2000});
    end
    memReady = 1'b1;
    memRdata = 32'h55AA33CC;
    @(negedge clk);
    memReady = 1'b0;
    instrValid = 1'b0;
    chk("R6 no second request", 32'(memValid), 32'd0);
    @(negedge clk);
    chk("R6 idle after load", {30'd0, busy, memValid}, 32'd0);
    // R5: loaded word visible through a store
    v = '{1'b0, 6'h0A, 5'd14, 5'd0, 16'h0005, 32'h0, 1'b1, 32'h00002008, 4'hF, 32'h55AA33CC};
    runVec(v, 1);

    finishRun();
  end
endmodule